// File: doc/BRIEF.md
# Fetch-stage gshare predictor with direction-gated target lookup

This block predicts branches for a fetch stage. A global history register is XORed with word-address bits of the fetch address. The result picks a 2-bit saturating counter in a direction table. The table is read in the cycle the fetch address is presented, and it returns the two neighbouring counters of a row. In the next cycle, a single 2:1 multiplexer, steered by the low index bit kept from the previous cycle, selects one counter.

The tagged, direct-mapped target buffer is looked up in that second cycle, and only when the selected counter says taken. A fetch that lands in the counter row already held, with no history change since, reuses the held row and does not read the table again.

A resolve port trains the counter, shifts the real outcome into the history and installs the target of taken branches. Two free-running counters report table reads and buffer reads so that access activity can be measured.

Top module: `bp_gated_gshare`

## Requirements
- R1: After reset, `pred_valid_o` is 0, both access counters are 0, the history is 0, the target buffer holds no valid entry and every counter is 01 (weakly not taken), so a first fetch predicts not taken.
- R2: A fetch with `fetch_valid_i` high in cycle t gives `pred_valid_o` high in cycle t+1. The counter used has index `fetch_pc_i[11:2] ^ history`, and `pred_taken_o` is 1 when that counter is 2 or 3.
- R3: A resolve updates the counter at index `res_pc_i[11:2] ^ history`, using the history before this resolve. The counter counts up on taken and down on not taken, and saturates at 3 and 0. If a fetch in the same cycle reads that counter, it sees the updated value.
- R4: Each resolve shifts the outcome in at the bottom of the history: history becomes {history[8:0], taken}.
- R5: The target buffer has 64 entries, indexed by pc[7:2] and tagged with pc[31:8]. A taken resolve writes tag and target. `pred_hit_o` is 1 only when the looked-up entry is valid and its tag matches. `pred_target_o` shows the stored target on a hit and 0 otherwise.
- R6: The target buffer is read only in a cycle with `pred_valid_o` and `pred_taken_o` both high. `btb_rd_cnt_o` grows by exactly one in each such cycle and holds in all others.
- R7: A fetch skips the table read when it falls in the counter row held from the last read, that row has been held since without any resolve, and no resolve happens in the same cycle. `pht_rd_cnt_o` counts only the fresh reads.
- R8: Direction, hit and target equal those of an ungated gshare predictor of the same size and the same update rules, for any stimulus.
- R9: With `fetch_valid_i` low, the next cycle has `pred_valid_o` low, `pred_taken_o` and `pred_hit_o` low, and no table read is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetch address is presented |
| fetch_pc_i | input | 30 | Fetch word address, pc[31:2] |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | 30 | Word address of the resolving branch |
| res_taken_i | input | 1 | Actual outcome of the resolving branch |
| res_target_i | input | 32 | Actual target of the resolving branch |
| pred_valid_o | output | 1 | Prediction for the previous cycle's fetch |
| pred_taken_o | output | 1 | Predicted direction |
| pred_hit_o | output | 1 | Target buffer hit, possible only when taken |
| pred_target_o | output | 32 | Predicted target, 0 without a hit |
| pht_rd_cnt_o | output | 32 | Number of fresh direction-table reads |
| btb_rd_cnt_o | output | 32 | Number of target-buffer reads |

## Verification
The assertions assume that the fetch and resolve inputs hold steady around the rising edge and are low while reset is applied. They also assume the access counters are read as values that wrap, never as values near their limit. The stimulus changes inputs only on falling edges, and it holds every input at 0 during each reset. It runs far fewer cycles than a counter wrap would need. The mix of sequential fetches, tag aliases, same-cycle read and write, and long runs of one outcome comes from a fixed vector table plus directed sequences. A cycle-accurate ungated model in the bench supplies every expected value.

// File: rtl/bp_gshare_pkg.sv
package bp_gshare_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic ctr_taken(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (shift_i) hist_o <= {hist_o[HIST_W-2:0], bit_i};
  end
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_gshare_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ROW_W  = IDX_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  output ctr_t             ctr_o,
  output logic [CNT_W-1:0] rd_cnt_o
);
  ctr_t             mem [ENTRIES];
  ctr_t             rd_pair [2];
  ctr_t             pair_q [2];
  logic [ROW_W-1:0] row, last_row_q;
  logic             sel_q, pair_ok_q, fresh;

  assign row   = rd_idx_i[IDX_W-1:1];
  assign fresh = rd_req_i && !(pair_ok_q && !wr_en_i && row == last_row_q);

  // write-first bypass: a same-cycle update wins over the early read
  for (genvar k = 0; k < 2; k++) begin : g_lane
    localparam logic [0:0] LANE = 1'(k);
    logic [IDX_W-1:0] lane_idx;
    assign lane_idx   = {row, LANE};
    assign rd_pair[k] = (wr_en_i && wr_idx_i == lane_idx)
                        ? ctr_next(mem[lane_idx], wr_taken_i) : mem[lane_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= ctr_next(mem[wr_idx_i], wr_taken_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q[0]  <= CTR_INIT;
      pair_q[1]  <= CTR_INIT;
      last_row_q <= '0;
      sel_q      <= 1'b0;
      pair_ok_q  <= 1'b0;
      rd_cnt_o   <= '0;
    end else begin
      if (fresh) begin
        pair_q[0]  <= rd_pair[0];
        pair_q[1]  <= rd_pair[1];
        last_row_q <= row;
        rd_cnt_o   <= rd_cnt_o + 1'b1;
      end
      if (rd_req_i) sel_q <= rd_idx_i[0];
      if (wr_en_i)       pair_ok_q <= 1'b0;
      else if (rd_req_i) pair_ok_q <= 1'b1;
    end
  end

  assign ctr_o = pair_q[sel_q];
endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  localparam int BIDX_W = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - 2 - BIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:2] rd_pc_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:2] wr_pc_i,
  input  logic [ADDR_W-1:0] wr_target_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [BIDX_W-1:0]  ri, wi;

  assign ri = rd_pc_i[BIDX_W+1:2];
  assign wi = wr_pc_i[BIDX_W+1:2];

  assign hit_o    = rd_en_i && valid_q[ri] && tag_q[ri] == rd_pc_i[ADDR_W-1:BIDX_W+2];
  assign target_o = hit_o ? tgt_q[ri] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      rd_cnt_o <= '0;
    end else begin
      if (wr_en_i) valid_q[wi] <= 1'b1;
      if (rd_en_i) rd_cnt_o <= rd_cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wi] <= wr_pc_i[ADDR_W-1:BIDX_W+2];
      tgt_q[wi] <= wr_target_i;
    end
  end
endmodule

// File: rtl/bp_gated_gshare.sv
module bp_gated_gshare
  import bp_gshare_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PHT_ENTRIES = 1024,
  parameter int HIST_W      = 10,
  parameter int BTB_ENTRIES = 64,
  parameter int CNT_W       = 32,
  localparam int IDX_W      = $clog2(PHT_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:2] fetch_pc_i,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:2] res_pc_i,
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_target_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              pred_hit_o,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic [CNT_W-1:0]  pht_rd_cnt_o,
  output logic [CNT_W-1:0]  btb_rd_cnt_o
);
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  hist_idx, fetch_idx, res_idx;
  logic [ADDR_W-1:2] pred_pc_q;
  ctr_t              ctr;
  logic              btb_en;

  assign hist_idx  = IDX_W'(hist);
  assign fetch_idx = fetch_pc_i[IDX_W+1:2] ^ hist_idx;
  assign res_idx   = res_pc_i[IDX_W+1:2] ^ hist_idx;

  bp_ghr #(.HIST_W(HIST_W)) i_ghr (
    .clk_i, .rst_ni,
    .shift_i (res_valid_i),
    .bit_i   (res_taken_i),
    .hist_o  (hist)
  );

  bp_pht #(.ENTRIES(PHT_ENTRIES), .CNT_W(CNT_W)) i_pht (
    .clk_i, .rst_ni,
    .rd_req_i   (fetch_valid_i),
    .rd_idx_i   (fetch_idx),
    .wr_en_i    (res_valid_i),
    .wr_idx_i   (res_idx),
    .wr_taken_i (res_taken_i),
    .ctr_o      (ctr),
    .rd_cnt_o   (pht_rd_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_pc_q    <= '0;
    end else begin
      pred_valid_o <= fetch_valid_i;
      if (fetch_valid_i) pred_pc_q <= fetch_pc_i;
    end
  end

  assign pred_taken_o = pred_valid_o && ctr_taken(ctr);
  assign btb_en       = pred_taken_o;

  bp_btb #(.ENTRIES(BTB_ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_btb (
    .clk_i, .rst_ni,
    .rd_en_i     (btb_en),
    .rd_pc_i     (pred_pc_q),
    .hit_o       (pred_hit_o),
    .target_o    (pred_target_o),
    .rd_cnt_o    (btb_rd_cnt_o),
    .wr_en_i     (res_valid_i && res_taken_i),
    .wr_pc_i     (res_pc_i),
    .wr_target_i (res_target_i)
  );
endmodule

// File: rtl/bp_gated_gshare_chk.sv
module bp_gated_gshare_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              pred_valid_o,
  input logic              pred_taken_o,
  input logic              pred_hit_o,
  input logic [ADDR_W-1:0] pred_target_o,
  input logic [CNT_W-1:0]  pht_rd_cnt_o,
  input logic [CNT_W-1:0]  btb_rd_cnt_o
);
  AST_HIT_NEEDS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_hit_o |-> (pred_valid_o && pred_taken_o)); // R6
  AST_TARGET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_target_o == '0); // R5
  AST_PRED_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> pred_valid_o); // R2
  AST_IDLE_NO_PRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !pred_valid_o); // R9
  AST_BTB_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_o && pred_taken_o) |=> btb_rd_cnt_o == $past(btb_rd_cnt_o) + 1'b1); // R6
  AST_BTB_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pred_valid_o && pred_taken_o) |=> $stable(btb_rd_cnt_o)); // R6
  AST_PHT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> $stable(pht_rd_cnt_o)); // R9
  AST_PHT_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> (pht_rd_cnt_o - $past(pht_rd_cnt_o)) <= CNT_W'(1)); // R7
endmodule

bind bp_gated_gshare bp_gated_gshare_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .pred_valid_o  (pred_valid_o),
  .pred_taken_o  (pred_taken_o),
  .pred_hit_o    (pred_hit_o),
  .pred_target_o (pred_target_o),
  .pht_rd_cnt_o  (pht_rd_cnt_o),
  .btb_rd_cnt_o  (btb_rd_cnt_o)
);

// File: tb/test_bp_gated_gshare.sv
module test_bp_gated_gshare;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:2] fetch_pc_i = '0;
  logic        res_valid_i = 1'b0;
  logic [31:2] res_pc_i = '0;
  logic        res_taken_i = 1'b0;
  logic [31:0] res_target_i = '0;
  logic        pred_valid_o, pred_taken_o, pred_hit_o;
  logic [31:0] pred_target_o, pht_rd_cnt_o, btb_rd_cnt_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  bp_gated_gshare i_bp_gated_gshare (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // ungated reference model
  logic [1:0]  m_pht [1024];
  logic [9:0]  m_ghr;
  logic        m_bv [64];
  logic [23:0] m_btag [64];
  logic [31:0] m_btgt [64];
  int          m_btb_cnt, m_fetches;
  logic        exp_valid, exp_taken;
  logic [31:0] exp_pc;

  typedef struct packed {
    logic fv; logic [15:0] pc; logic rv; logic [15:0] rpc; logic rt; logic [15:0] tgt;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h0104, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h0108, 1'b1, 16'h0104, 1'b1, 16'h0800},
    '{1'b1, 16'h010C, 1'b1, 16'h0104, 1'b1, 16'h0800},
    '{1'b0, 16'h0000, 1'b1, 16'h0104, 1'b1, 16'h0800},
    '{1'b1, 16'h0104, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h0104, 1'b1, 16'h2104, 1'b1, 16'h0A00},
    '{1'b1, 16'h2104, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h0104, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h0200, 1'b1, 16'h0200, 1'b0, 16'h0000},
    '{1'b1, 16'h0204, 1'b1, 16'h0300, 1'b1, 16'h0340},
    '{1'b1, 16'h0300, 1'b1, 16'h0300, 1'b1, 16'h0340},
    '{1'b1, 16'h0304, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h0300, 1'b1, 16'h0300, 1'b1, 16'h0340},
    '{1'b1, 16'h0300, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 16'h2104, 1'b1, 16'h0104, 1'b0, 16'h0000},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000}
  };

  function automatic logic [1:0] m_next(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) m_pht[i] = 2'b01;
    for (int i = 0; i < 64; i++) m_bv[i] = 1'b0;
    m_ghr = '0; m_btb_cnt = 0; m_fetches = 0;
    exp_valid = 1'b0; exp_taken = 1'b0; exp_pc = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; fetch_valid_i = 1'b0; res_valid_i = 1'b0;
    fetch_pc_i = '0; res_pc_i = '0; res_taken_i = 1'b0; res_target_i = '0;
    repeat (2) @(negedge clk_i);
    model_clear();
    rst_ni = 1'b1;
    #1;
    chk(pred_valid_o == 1'b0, "R1 pred_valid after reset", 32'(pred_valid_o), 0);
    chk(pht_rd_cnt_o == 0, "R1 pht count after reset", pht_rd_cnt_o, 0);
    chk(btb_rd_cnt_o == 0, "R1 btb count after reset", btb_rd_cnt_o, 0);
    @(negedge clk_i);
  endtask

  // called at a falling edge: check last fetch, drive this cycle, advance model
  task automatic step(input logic fv, input logic [31:0] pc, input logic rv,
                      input logic [31:0] rpc, input logic rt, input logic [31:0] tgt);
    logic [5:0]  bi;
    logic        eh;
    logic [31:0] et;
    logic [9:0]  idx, ridx;
    logic [1:0]  c;
    bi = exp_pc[7:2];
    eh = exp_valid && exp_taken && m_bv[bi] && m_btag[bi] == exp_pc[31:8];
    et = eh ? m_btgt[bi] : 32'h0;
    chk(pred_valid_o == exp_valid, "R8 valid", 32'(pred_valid_o), 32'(exp_valid));
    chk(pred_taken_o == (exp_valid && exp_taken), "R8 direction", 32'(pred_taken_o), 32'(exp_valid && exp_taken));
    chk(pred_hit_o == eh, "R8 hit", 32'(pred_hit_o), 32'(eh));
    chk(pred_target_o == et, "R8 target", pred_target_o, et);
    chk(btb_rd_cnt_o == 32'(m_btb_cnt), "R6 btb count", btb_rd_cnt_o, 32'(m_btb_cnt));
    if (exp_valid && exp_taken) m_btb_cnt++;
    fetch_valid_i = fv; fetch_pc_i = pc[31:2];
    res_valid_i = rv; res_pc_i = rpc[31:2]; res_taken_i = rt; res_target_i = tgt;
    idx  = pc[11:2] ^ m_ghr;
    ridx = rpc[11:2] ^ m_ghr;
    c = m_pht[idx];
    if (rv && ridx == idx) c = m_next(c, rt);
    exp_valid = fv; exp_taken = c[1]; exp_pc = pc;
    if (fv) m_fetches++;
    if (rv) begin
      m_pht[ridx] = m_next(m_pht[ridx], rt);
      if (rt) begin
        m_bv[rpc[7:2]] = 1'b1; m_btag[rpc[7:2]] = rpc[31:8]; m_btgt[rpc[7:2]] = tgt;
      end
      m_ghr = {m_ghr[8:0], rt};
    end
    @(negedge clk_i);
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    model_clear();
    do_reset();

    // vector table
    for (int i = 0; i < NV; i++)
      step(VECS[i].fv, {16'h0, VECS[i].pc}, VECS[i].rv, {16'h0, VECS[i].rpc},
           VECS[i].rt, {16'h0, VECS[i].tgt});
    chk(pht_rd_cnt_o < 32'(m_fetches), "R7 fewer reads than fetches", pht_rd_cnt_o, 32'(m_fetches));
    chk(btb_rd_cnt_o < 32'(m_fetches), "R6 gated below ungated reads", btb_rd_cnt_o, 32'(m_fetches));

    // R1: first prediction weakly not taken, no buffer read
    do_reset();
    step(1'b1, 32'h300, 1'b0, 32'h0, 1'b0, 32'h0);
    chk(pred_taken_o == 1'b0, "R1 initial not taken", 32'(pred_taken_o), 0);
    idle();
    chk(btb_rd_cnt_o == 0, "R6 no read on not taken", btb_rd_cnt_o, 0);

    // R7 / R9: row reuse and idle cycles
    do_reset();
    step(1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 32'h0);
    step(1'b1, 32'h104, 1'b0, 32'h0, 1'b0, 32'h0);
    step(1'b1, 32'h108, 1'b0, 32'h0, 1'b0, 32'h0);
    idle();
    chk(pht_rd_cnt_o == 2, "R7 pair reused", pht_rd_cnt_o, 2);
    chk(pred_valid_o == 1'b0, "R9 no prediction when idle", 32'(pred_valid_o), 0);
    idle();
    chk(pht_rd_cnt_o == 2, "R9 no read when idle", pht_rd_cnt_o, 2);

    // R3: same-cycle update wins over read; R5 target written at that edge
    do_reset();
    step(1'b1, 32'h500, 1'b1, 32'h500, 1'b1, 32'h900);
    chk(pred_taken_o == 1'b1, "R3 write priority", 32'(pred_taken_o), 1);
    chk(pred_target_o == 32'h900, "R5 target on hit", pred_target_o, 32'h900);
    idle();

    // R4: outcome enters history bit 0
    do_reset();
    step(1'b0, 32'h0, 1'b1, 32'h500, 1'b1, 32'h900);
    step(1'b1, 32'h504, 1'b0, 32'h0, 1'b0, 32'h0);
    chk(pred_taken_o == 1'b1, "R4 history shift", 32'(pred_taken_o), 1);
    idle();

    // R3: lower saturation
    do_reset();
    repeat (3) step(1'b0, 32'h0, 1'b1, 32'h500, 1'b0, 32'h0);
    step(1'b0, 32'h0, 1'b1, 32'h500, 1'b1, 32'h900);
    step(1'b1, 32'h504, 1'b0, 32'h0, 1'b0, 32'h0);
    chk(pred_taken_o == 1'b0, "R3 saturate at 0", 32'(pred_taken_o), 0);
    idle();

    // R3: upper saturation, then R5 tag alias
    do_reset();
    repeat (13) step(1'b0, 32'h0, 1'b1, 32'h500, 1'b1, 32'h900);
    step(1'b1, 32'h500, 1'b0, 32'h0, 1'b0, 32'h0);
    chk(pred_taken_o == 1'b1, "R3 saturate at 3", 32'(pred_taken_o), 1);
    chk(pred_hit_o == 1'b1, "R5 hit after install", 32'(pred_hit_o), 1);
    step(1'b0, 32'h0, 1'b1, 32'h2500, 1'b1, 32'hA00);
    step(1'b1, 32'h500, 1'b0, 32'h0, 1'b0, 32'h0);
    chk(pred_hit_o == 1'b0, "R5 tag mismatch misses", 32'(pred_hit_o), 0);
    chk(pred_target_o == 32'h0, "R5 target zero on miss", pred_target_o, 0);
    idle();

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule